// File: doc/BRIEF.md
# Power-On Start-Up Sequencer

This block brings a processor core out of reset after a power-on trip. While the trip input is high, the core is held and the 14-bit fuse word is captured and decoded. Once the trip falls, the block can run a power-up delay counted on a slow internal oscillator. In crystal oscillator modes it then runs a second delay of main-clock cycles, so that the crystal has time to settle. The core is released only when every delay that applies has ended.

The fuse word is active-low in places. Bit 3 enables the power-up delay when it is 0. Bits 1:0 pick the oscillator mode, and the RC mode skips the main-clock delay entirely. The second delay runs in the main-clock domain. Its start request and its completion flag each cross between the domains through a two-flop synchronizer.

On release, the block pulses a vector-load strobe for one cycle. The core uses it to zero its program counter, its high-address latch and its bank-select bits. A status image gives the flag values that follow a power-on.

Top module: `por_seq`

## Requirements
- R1: While `trip` is high, `core_hold` is 1 and `vec_load` is 0, and the fuse word is captured on every slow-clock edge.
- R2: Fuse bits 1:0 select the oscillator mode, encoded 00 LP, 01 XT, 10 HS, 11 RC, and shown on `osc_mode`. Bit 2 = 1 sets `wdt_en`. `cp_on` is 1 only when bits 13:4 are all 0.
- R3: With fuse bit 3 = 0 in RC mode, `core_hold` falls on the 1025th slow edge that samples `trip` low. With bit 3 = 1 in RC mode, it falls on the first such edge.
- R4: In LP, XT or HS mode, 1024 main-clock cycles follow the power-up delay. Counting from the first slow edge with `trip` low, the release lands between base+171 and base+181 slow edges, where base is 1025 with the delay and 1 without it. The main clock is 200 MHz and the slow clock is 33.3 MHz.
- R5: In RC mode the main-clock delay is never started.
- R6: `vec_load` is high for exactly one slow cycle: the cycle in which `core_hold` falls. `status_init` is 8'h18, which means bank bits 7:5 = 0, time-out bit 4 = 1, power-down bit 3 = 1, and the arithmetic flags in bits 2:0 driven 0.
- R7: A new `trip` pulse during either delay aborts the sequence. Timing restarts from the power-up delay once `trip` falls again.
- R8: Changes to `cfg_word` while `trip` is low have no effect on timing or on the decoded outputs.
- R9: The erased word 14'h3FFF gives RC mode, watchdog on, no power-up delay and no code protection, so release comes on the first slow edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Internal slow oscillator clock |
| clk_main | input | 1 | Main oscillator clock |
| trip | input | 1 | Power-on trip, high while supply is below threshold; synchronous to clk_slow |
| cfg_word | input | 14 | Fuse configuration word |
| core_hold | output | 1 | Core reset, high while start-up is in progress |
| vec_load | output | 1 | One-cycle strobe to zero PC, its latch and bank bits |
| status_init | output | 8 | Status register value after power-on |
| osc_mode | output | 2 | Decoded oscillator mode |
| wdt_en | output | 1 | Watchdog enable fuse |
| cp_on | output | 1 | Code protection active |

## Verification
The hardest case to reach is an abort that lands while the main-clock delay is running. To hit it, the trip must rise after the start request has crossed into the main domain and before the done flag has come back. The bench releases an XT configuration with no power-up delay and waits 80 slow cycles, which is well inside the roughly 170-cycle window. It then pulses the trip and checks that the release timing restarts cleanly. The check that fuse changes are ignored is handled the same way: the word is switched mid-delay and the bench confirms that the release edge and the decoded outputs still follow the captured word.

// File: rtl/por_pkg.sv
`timescale 1ns/1ps
package por_pkg;

    localparam int CFG_W = 14;

    typedef enum logic [1:0] {
        OSC_LP = 2'b00,
        OSC_XT = 2'b01,
        OSC_HS = 2'b10,
        OSC_RC = 2'b11
    } osc_mode_e;

    typedef struct packed {
        osc_mode_e mode;
        logic      wdt_en;
        logic      pwrt_en;
        logic      cp_on;
    } fuse_t;

    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_PWRT = 2'd1,
        SEQ_OST  = 2'd2,
        SEQ_RUN  = 2'd3
    } seq_state_e;

    // Fuse bit 3 is active-low for the delay; bits 13:4 protect when all cleared.
    function automatic fuse_t decode_fuses(input logic [CFG_W-1:0] w);
        fuse_t f;
        f.mode    = osc_mode_e'(w[1:0]);
        f.wdt_en  = w[2];
        f.pwrt_en = ~w[3];
        f.cp_on   = (w[CFG_W-1:4] == '0);
        return f;
    endfunction

    function automatic logic needs_ost(input osc_mode_e m);
        return m != OSC_RC;
    endfunction

    // Bank bits 7:5 cleared, TO (4) and PD (3) set, arithmetic flags driven 0.
    function automatic logic [7:0] status_after_por();
        return 8'b000_1_1_000;
    endfunction

endpackage

// File: rtl/por_sync2.sv
`timescale 1ns/1ps
module por_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/por_fuse_latch.sv
`timescale 1ns/1ps
module por_fuse_latch
    import por_pkg::*;
(
    input  logic             clk,
    input  logic             capture,
    input  logic [CFG_W-1:0] cfg_word,
    output fuse_t            fuse
);
    always_ff @(posedge clk) begin
        if (capture) fuse <= decode_fuses(cfg_word);
    end
endmodule

// File: rtl/por_slow_seq.sv
`timescale 1ns/1ps
module por_slow_seq
    import por_pkg::*;
#(
    parameter int PWRT_W = 10
) (
    input  logic clk,
    input  logic trip,
    input  logic pwrt_en,
    input  logic ost_needed,
    input  logic done_sync,
    output logic start_req,
    output logic core_hold,
    output logic vec_load
);
    localparam logic [PWRT_W-1:0] PWRT_LAST = {PWRT_W{1'b1}};

    seq_state_e        state, nxt;
    logic [PWRT_W-1:0] cnt;

    // Target once the power-up delay is over (or skipped).
    function automatic seq_state_e after_pwrt(input logic ost, input logic dsync);
        if (!ost)        return SEQ_RUN;
        else if (!dsync) return SEQ_OST;
        else             return SEQ_HOLD;
    endfunction

    always_comb begin
        nxt = state;
        case (state)
            SEQ_HOLD: begin
                if (pwrt_en) nxt = SEQ_PWRT;
                else         nxt = after_pwrt(ost_needed, done_sync);
            end
            SEQ_PWRT: begin
                if (cnt == PWRT_LAST) begin
                    nxt = after_pwrt(ost_needed, done_sync);
                    if (nxt == SEQ_HOLD) nxt = SEQ_PWRT;
                end
            end
            SEQ_OST:  if (done_sync) nxt = SEQ_RUN;
            default:  nxt = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (trip) begin
            state     <= SEQ_HOLD;
            cnt       <= '0;
            vec_load  <= 1'b0;
            start_req <= 1'b0;
        end else begin
            state     <= nxt;
            cnt       <= (state == SEQ_PWRT && cnt != PWRT_LAST) ? cnt + 1'b1 :
                         (state == SEQ_PWRT) ? cnt : '0;
            vec_load  <= (nxt == SEQ_RUN) && (state != SEQ_RUN);
            start_req <= (nxt == SEQ_OST);
        end
    end

    assign core_hold = (state != SEQ_RUN);

    p_trip_holds_r1: assert property (@(posedge clk)
        trip |=> (core_hold && !vec_load));

    p_ost_waits_done_r4: assert property (@(posedge clk) disable iff (trip)
        (state == SEQ_OST && !done_sync) |=> core_hold);

    p_rc_no_ost_r5: assert property (@(posedge clk) disable iff (trip)
        !ost_needed |-> !start_req);

    p_vec_single_r6: assert property (@(posedge clk) disable iff (trip)
        vec_load |=> !vec_load);

    p_release_strobe_r6: assert property (@(posedge clk) disable iff (trip)
        $fell(core_hold) |-> vec_load);
endmodule

// File: rtl/por_ost_timer.sv
`timescale 1ns/1ps
module por_ost_timer #(
    parameter int OST_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic trip,
    input  logic start_req,
    output logic done
);
    localparam logic [OST_W-1:0] OST_LAST = {OST_W{1'b1}};

    logic             rst_m, start_m;
    logic [OST_W-1:0] cnt;

    por_sync2 #(.STAGES(SYNC_STAGES)) u_trip_sync  (.clk(clk), .d(trip),      .q(rst_m));
    por_sync2 #(.STAGES(SYNC_STAGES)) u_start_sync (.clk(clk), .d(start_req), .q(start_m));

    always_ff @(posedge clk) begin
        if (rst_m || !start_m) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == OST_LAST) done <= 1'b1;
            else                 cnt  <= cnt + 1'b1;
        end
    end

    p_done_needs_start_r4: assert property (@(posedge clk) disable iff (rst_m)
        !start_m |=> !done);

    p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst_m)
        (done && start_m) |=> done);
endmodule

// File: rtl/por_seq.sv
`timescale 1ns/1ps
module por_seq
    import por_pkg::*;
#(
    parameter int PWRT_W      = 10,
    parameter int OST_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_slow,
    input  logic        clk_main,
    input  logic        trip,
    input  logic [13:0] cfg_word,
    output logic        core_hold,
    output logic        vec_load,
    output logic [7:0]  status_init,
    output logic [1:0]  osc_mode,
    output logic        wdt_en,
    output logic        cp_on
);
    fuse_t fuse;
    logic  start_req, done_main, done_sync;

    por_fuse_latch u_fuse (
        .clk(clk_slow), .capture(trip), .cfg_word(cfg_word), .fuse(fuse)
    );

    por_slow_seq #(.PWRT_W(PWRT_W)) u_seq (
        .clk(clk_slow), .trip(trip), .pwrt_en(fuse.pwrt_en),
        .ost_needed(needs_ost(fuse.mode)), .done_sync(done_sync),
        .start_req(start_req), .core_hold(core_hold), .vec_load(vec_load)
    );

    por_ost_timer #(.OST_W(OST_W), .SYNC_STAGES(SYNC_STAGES)) u_ost (
        .clk(clk_main), .trip(trip), .start_req(start_req), .done(done_main)
    );

    por_sync2 #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk(clk_slow), .d(done_main), .q(done_sync)
    );

    assign status_init = status_after_por();
    assign osc_mode    = fuse.mode;
    assign wdt_en      = fuse.wdt_en;
    assign cp_on       = fuse.cp_on;

    p_fuse_stable_r8: assert property (@(posedge clk_slow) disable iff (trip)
        $stable(fuse));
endmodule

// File: tb/por_seq_bench.sv
`timescale 1ns/1ps
module por_seq_bench;
    logic        clk_slow = 0, clk_main = 0, trip = 1;
    logic [13:0] cfg_word = 14'h3FFF;
    logic        core_hold, vec_load, wdt_en, cp_on;
    logic [7:0]  status_init;
    logic [1:0]  osc_mode;

    por_seq u_por_seq (
        .clk_slow(clk_slow), .clk_main(clk_main), .trip(trip), .cfg_word(cfg_word),
        .core_hold(core_hold), .vec_load(vec_load), .status_init(status_init),
        .osc_mode(osc_mode), .wdt_en(wdt_en), .cp_on(cp_on)
    );

    always #15 clk_slow = ~clk_slow;
    initial begin #1; forever #2.5 clk_main = ~clk_main; end

    typedef struct {
        int lo; int hi; logic [1:0] mode; logic wdt; logic cp; string req;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   checks = 0, failures = 0, edges = 0;
    bit   armed = 0, finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: counts slow edges since trip fell, compares at release.
    always @(posedge clk_slow) begin
        #1;
        if (trip) begin
            edges = 0;
            armed = 1;
        end else if (armed) begin
            edges++;
            if (!core_hold) begin
                armed = 0;
                if (q.size() == 0) begin
                    check(0, "R6", "unexpected release", edges, 0);
                end else begin
                    cur = q.pop_front();
                    check(edges >= cur.lo && edges <= cur.hi, cur.req, "release edge", edges, cur.lo);
                    check(vec_load == 1'b1, "R6", "vec_load at release", vec_load, 1);
                    check(osc_mode == cur.mode, "R2", "osc_mode", osc_mode, cur.mode);
                    check(wdt_en == cur.wdt, "R2", "wdt_en", wdt_en, cur.wdt);
                    check(cp_on == cur.cp, "R2", "cp_on", cp_on, cur.cp);
                    check(status_init == 8'h18, "R6", "status_init", status_init, 8'h18);
                end
            end else if (vec_load) begin
                check(0, "R6", "vec_load while held", 1, 0);
            end
        end else if (!core_hold && vec_load) begin
            check(0, "R6", "second vec_load pulse", 1, 0);
        end
    end

    // Driver: captures cfg, pushes expectation, runs optional abort or fuse change.
    task automatic run_case(input logic [13:0] cfg, input int abort_at, input int change_at,
                            input logic [13:0] new_cfg, input string req);
        exp_t e;
        int   base;
        @(negedge clk_slow);
        trip = 1;
        cfg_word = cfg;
        repeat (4) @(negedge clk_slow);
        check(core_hold == 1'b1, "R1", "hold while trip high", core_hold, 1);
        base   = cfg[3] ? 1 : 1025;
        e.lo   = (cfg[1:0] == 2'b11) ? base : base + 171;
        e.hi   = (cfg[1:0] == 2'b11) ? base : base + 181;
        e.mode = cfg[1:0];
        e.wdt  = cfg[2];
        e.cp   = (cfg[13:4] == 10'd0);
        e.req  = req;
        q.push_back(e);
        trip = 0;
        if (abort_at > 0) begin
            repeat (abort_at) @(negedge clk_slow);
            trip = 1;
            repeat (3) @(negedge clk_slow);
            check(core_hold == 1'b1, "R7", "hold during abort", core_hold, 1);
            trip = 0;
        end
        if (change_at > 0) begin
            repeat (change_at) @(negedge clk_slow);
            cfg_word = new_cfg;
        end
        wait (q.size() == 0);
        repeat (5) @(negedge clk_slow);
        check(core_hold == 1'b0, req, "stays released", core_hold, 0);
    endtask

    initial begin
        repeat (6) @(negedge clk_slow);
        check(core_hold == 1'b1, "R1", "reset hold", core_hold, 1);
        check(vec_load == 1'b0, "R1", "reset vec_load", vec_load, 0);
        check(status_init == 8'h18, "R6", "reset status", status_init, 8'h18);

        run_case(14'h3FFF, 0, 0, 14'h0, "R9");   // erased word
        run_case(14'h3FF7, 0, 0, 14'h0, "R3");   // RC with power-up delay (R5)
        run_case(14'h3FF1, 0, 0, 14'h0, "R4");   // XT with delay, watchdog off
        run_case(14'h0000, 0, 0, 14'h0, "R4");   // LP, code protected, delay on
        run_case(14'h3FFE, 0, 0, 14'h0, "R4");   // HS without delay
        run_case(14'h3FF7, 500, 0, 14'h0, "R7"); // abort inside power-up delay
        run_case(14'h3FFD, 80, 0, 14'h0, "R7");  // abort inside oscillator delay
        run_case(14'h3FF7, 0, 300, 14'h3FF9, "R8"); // fuse change ignored

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #950000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule